// File: doc/BRIEF.md
# Dual-Port Semaphore Token Unit

This unit holds eight one-bit ownership tokens that two independent ports, left and right, share. Each port names a token with a 3-bit index. It claims the token by writing 0 on its data bit, gives the token back by writing 1, and tests the token by reading it. A read returns the port's own view of the token: 0 means "this port holds it", and 1 means the other port holds it or nobody does. The view bit is copied across the whole read word.

A claim that cannot be granted at once is not lost. It stays pending, and the token passes straight to the waiting port when the holder gives it back. A waiting port can cancel its claim by writing 1 before that happens. When both ports claim a free token in the same cycle, the left port gets it and the right port's claim stays pending. A synchronous reset leaves every token free with no pending claims.

Top module: `sem_token_unit`

## Requirements
- R1: After synchronous reset, all eight tokens are free with no pending claims, and both read words are all ones.
- R2: A read returns a word of DATA_W copies of one bit. The bit is 0 when the reading port holds the indexed token and 1 otherwise.
- R3: A write of 0 (strobe high, write high, data 0) to a free token gives it to the writing port at the next clock edge.
- R4: A write of 1 by the holder, with no claim pending from the other port, leaves the token free, so that both ports read 1.
- R5: A claim made while the other port holds the token stays pending. When the holder writes 1, the token passes directly to the waiting port.
- R6: A waiting port that writes 1 before the holder releases cancels its claim, and the later release leaves the token free.
- R7: A write of 0 from the port that does not hold the token never takes the token from the holder, and a repeated claim changes nothing.
- R8: When both ports write 0 to the same free token in one cycle, the left port gets it and the right port's claim stays pending.
- R9: The two ports never hold the same token at once, so they never both read 0 for it.
- R10: Read data is registered. It reflects the token state at the clock edge where the read strobe is sampled, so a read in the cycle after a write sees that write. The word holds its value until the next read on that port.
- R11: An operation on one token leaves every other token unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lVld | input | 1 | Left port access strobe |
| lWr | input | 1 | Left port: 1 = write, 0 = read |
| lAddr | input | 3 | Left port token index |
| lDin | input | 1 | Left port write bit (0 = claim, 1 = release) |
| lRdata | output | DATA_W | Left port read word |
| rVld | input | 1 | Right port access strobe |
| rWr | input | 1 | Right port: 1 = write, 0 = read |
| rAddr | input | 3 | Right port token index |
| rDin | input | 1 | Right port write bit (0 = claim, 1 = release) |
| rRdata | output | DATA_W | Right port read word |

## Verification
A write changes token ownership at the first clock edge that samples it. A read strobe loads the read word at the first edge that samples it, so the result is due one cycle after the read is driven. The bench drives each vector on a falling edge and samples on the next falling edge, after exactly one rising edge. A read issued right after a write therefore shows the state that write produced. For cycles without a read, the bench checks that the read words keep their value. After reset it checks that both words are all ones.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int FLAG_BITS = 3;
  localparam int NUM_FLAGS = 1 << FLAG_BITS;

  // Strobes from the decoder to the token store and read ports
  typedef struct packed {
    logic [NUM_FLAGS-1:0] setReqL;
    logic [NUM_FLAGS-1:0] clrReqL;
    logic [NUM_FLAGS-1:0] setReqR;
    logic [NUM_FLAGS-1:0] clrReqR;
    logic                 rdL;
    logic                 rdR;
    logic [FLAG_BITS-1:0] idxL;
    logic [FLAG_BITS-1:0] idxR;
  } semCmd_t;
endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
(
  input  logic                 lVld,
  input  logic                 lWr,
  input  logic [FLAG_BITS-1:0] lAddr,
  input  logic                 lDin,
  input  logic                 rVld,
  input  logic                 rWr,
  input  logic [FLAG_BITS-1:0] rAddr,
  input  logic                 rDin,
  output semCmd_t              cmd
);
  always_comb begin
    cmd = '0;
    if (lVld && lWr) begin
      if (lDin) cmd.clrReqL[lAddr] = 1'b1;
      else      cmd.setReqL[lAddr] = 1'b1;
    end
    if (rVld && rWr) begin
      if (rDin) cmd.clrReqR[rAddr] = 1'b1;
      else      cmd.setReqR[rAddr] = 1'b1;
    end
    cmd.rdL  = lVld && !lWr;
    cmd.rdR  = rVld && !rWr;
    cmd.idxL = lAddr;
    cmd.idxR = rAddr;
  end
endmodule

// File: rtl/sem_flags.sv
module sem_flags
  import sem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  semCmd_t              cmd,
  output logic [NUM_FLAGS-1:0] ownL,
  output logic [NUM_FLAGS-1:0] ownR
);
  logic [NUM_FLAGS-1:0] reqL, reqR;
  logic [NUM_FLAGS-1:0] reqLNxt, reqRNxt, ownLNxt, ownRNxt;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    logic lReq, rReq;
    assign lReq = (reqL[g] | cmd.setReqL[g]) & ~cmd.clrReqL[g];
    assign rReq = (reqR[g] | cmd.setReqR[g]) & ~cmd.clrReqR[g];
    assign reqLNxt[g] = lReq;
    assign reqRNxt[g] = rReq;
    // A right holder keeps the token while it still wants it;
    // otherwise the left side has priority.
    always_comb begin
      if (ownR[g]) begin
        ownRNxt[g] = rReq;
        ownLNxt[g] = !rReq && lReq;
      end else begin
        ownLNxt[g] = lReq;
        ownRNxt[g] = !lReq && rReq;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqL <= '0;
      reqR <= '0;
      ownL <= '0;
      ownR <= '0;
    end else begin
      reqL <= reqLNxt;
      reqR <= reqRNxt;
      ownL <= ownLNxt;
      ownR <= ownRNxt;
    end
  end
endmodule

// File: rtl/sem_rd_port.sv
module sem_rd_port
  import sem_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd,
  input  logic [FLAG_BITS-1:0] idx,
  input  logic [NUM_FLAGS-1:0] own,
  output logic [DATA_W-1:0]    rdata
);
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '1;
    else if (rd) rdata <= {DATA_W{~own[idx]}};
  end
endmodule

// File: rtl/sem_token_unit.sv
module sem_token_unit
  import sem_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lVld,
  input  logic                 lWr,
  input  logic [FLAG_BITS-1:0] lAddr,
  input  logic                 lDin,
  output logic [DATA_W-1:0]    lRdata,
  input  logic                 rVld,
  input  logic                 rWr,
  input  logic [FLAG_BITS-1:0] rAddr,
  input  logic                 rDin,
  output logic [DATA_W-1:0]    rRdata
);
  semCmd_t              cmd;
  logic [NUM_FLAGS-1:0] ownL, ownR;

  sem_ctrl u_ctrl (
    .lVld(lVld), .lWr(lWr), .lAddr(lAddr), .lDin(lDin),
    .rVld(rVld), .rWr(rWr), .rAddr(rAddr), .rDin(rDin),
    .cmd(cmd)
  );

  sem_flags u_flags (
    .clk(clk), .rst(rst), .cmd(cmd), .ownL(ownL), .ownR(ownR)
  );

  sem_rd_port #(.DATA_W(DATA_W)) u_rdL (
    .clk(clk), .rst(rst), .rd(cmd.rdL), .idx(cmd.idxL), .own(ownL), .rdata(lRdata)
  );

  sem_rd_port #(.DATA_W(DATA_W)) u_rdR (
    .clk(clk), .rst(rst), .rd(cmd.rdR), .idx(cmd.idxR), .own(ownR), .rdata(rRdata)
  );
endmodule

// File: rtl/sem_token_chk.sv
module sem_token_chk
  import sem_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 lVld,
  input logic                 lWr,
  input logic [FLAG_BITS-1:0] lAddr,
  input logic                 lDin,
  input logic [DATA_W-1:0]    lRdata,
  input logic                 rVld,
  input logic                 rWr,
  input logic [FLAG_BITS-1:0] rAddr,
  input logic                 rDin,
  input logic [DATA_W-1:0]    rRdata,
  input logic [NUM_FLAGS-1:0] ownL,
  input logic [NUM_FLAGS-1:0] ownR
);
  logic lClaim, rClaim;
  assign lClaim = lVld && lWr && !lDin;
  assign rClaim = rVld && rWr && !rDin;

  AST_RESET_FREE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ownL == '0 && ownR == '0 && lRdata == '1 && rRdata == '1)); // R1

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (ownL & ownR) == '0); // R9

  AST_LEFT_WINS: assert property (@(posedge clk) disable iff (rst)
    (lClaim && rClaim && lAddr == rAddr && !ownL[lAddr] && !ownR[lAddr])
      |=> ownL[$past(lAddr)]); // R8

  AST_NO_STEAL: assert property (@(posedge clk) disable iff (rst)
    (ownL[rAddr] && rClaim && !(lVld && lWr && lAddr == rAddr))
      |=> ownL[$past(rAddr)]); // R7

  AST_READ_VIEW: assert property (@(posedge clk) disable iff (rst)
    (lVld && !lWr) |=> lRdata == {DATA_W{!$past(ownL[lAddr])}}); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(rVld && !rWr) && !$rose(rst)) |=> $stable(rRdata)); // R10
endmodule

bind sem_token_unit sem_token_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .lVld(lVld), .lWr(lWr), .lAddr(lAddr), .lDin(lDin), .lRdata(lRdata),
  .rVld(rVld), .rWr(rWr), .rAddr(rAddr), .rDin(rDin), .rRdata(rRdata),
  .ownL(ownL), .ownR(ownR)
);

// File: tb/sem_token_unit_tb.sv
module sem_token_unit_tb;
  localparam int DW = 16;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_REQ = 2'd1, OP_REL = 2'd2, OP_RD = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lVld = 0, lWr = 0, lDin = 0, rVld = 0, rWr = 0, rDin = 0;
  logic [2:0] lAddr = 0, rAddr = 0;
  logic [DW-1:0] lRdata, rRdata;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sem_token_unit #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .lVld(lVld), .lWr(lWr), .lAddr(lAddr), .lDin(lDin), .lRdata(lRdata),
    .rVld(rVld), .rWr(rWr), .rAddr(rAddr), .rDin(rDin), .rRdata(rRdata)
  );

  // {lOp, lIdx, rOp, rIdx, expL, expR, tag}
  localparam int NV = 25;
  localparam logic [15:0] VEC [NV] = '{
    {OP_RD,  3'd3, OP_RD,  3'd3, 1'b1, 1'b1, 4'd1},  // R1 fresh token free
    {OP_REQ, 3'd3, OP_IDLE,3'd0, 1'b0, 1'b0, 4'd3},  // R3 claim
    {OP_RD,  3'd3, OP_RD,  3'd3, 1'b0, 1'b1, 4'd3},  // R3 / R2 views
    {OP_IDLE,3'd0, OP_REQ, 3'd3, 1'b0, 1'b0, 4'd7},  // R7 right claims held token
    {OP_RD,  3'd3, OP_RD,  3'd3, 1'b0, 1'b1, 4'd7},  // R7 left keeps it
    {OP_IDLE,3'd0, OP_REQ, 3'd3, 1'b0, 1'b0, 4'd7},  // R7 repeated claim
    {OP_RD,  3'd3, OP_RD,  3'd3, 1'b0, 1'b1, 4'd7},  // R7 unchanged
    {OP_REL, 3'd3, OP_IDLE,3'd0, 1'b0, 1'b0, 4'd5},  // R5 holder releases
    {OP_RD,  3'd3, OP_RD,  3'd3, 1'b1, 1'b0, 4'd5},  // R5 passed to right
    {OP_REQ, 3'd3, OP_IDLE,3'd0, 1'b0, 1'b0, 4'd5},  // R5 left waits
    {OP_IDLE,3'd0, OP_REL, 3'd3, 1'b0, 1'b0, 4'd5},  // R5 right releases
    {OP_RD,  3'd3, OP_RD,  3'd3, 1'b0, 1'b1, 4'd5},  // R5 passed to left
    {OP_IDLE,3'd0, OP_REQ, 3'd3, 1'b0, 1'b0, 4'd6},  // R6 right waits
    {OP_IDLE,3'd0, OP_REL, 3'd3, 1'b0, 1'b0, 4'd6},  // R6 right withdraws
    {OP_REL, 3'd3, OP_IDLE,3'd0, 1'b0, 1'b0, 4'd6},  // R6 left releases
    {OP_RD,  3'd3, OP_RD,  3'd3, 1'b1, 1'b1, 4'd6},  // R6 token free
    {OP_REQ, 3'd5, OP_REQ, 3'd5, 1'b0, 1'b0, 4'd8},  // R8 simultaneous claim
    {OP_RD,  3'd5, OP_RD,  3'd5, 1'b0, 1'b1, 4'd8},  // R8 left wins
    {OP_REL, 3'd5, OP_IDLE,3'd0, 1'b0, 1'b0, 4'd8},  // R8 left releases
    {OP_RD,  3'd5, OP_RD,  3'd5, 1'b1, 1'b0, 4'd8},  // R8 right claim was pending
    {OP_IDLE,3'd0, OP_REL, 3'd5, 1'b0, 1'b0, 4'd4},  // R4 release, none pending
    {OP_RD,  3'd5, OP_RD,  3'd5, 1'b1, 1'b1, 4'd4},  // R4 free
    {OP_REQ, 3'd0, OP_IDLE,3'd0, 1'b0, 1'b0, 4'd11}, // R11 claim token 0
    {OP_RD,  3'd7, OP_RD,  3'd0, 1'b1, 1'b1, 4'd11}, // R11 token 7 untouched
    {OP_RD,  3'd0, OP_RD,  3'd7, 1'b0, 1'b1, 4'd11}  // R11 token 0 held by left
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] lOp, input logic [2:0] li,
                       input logic [1:0] rOp, input logic [2:0] ri);
    lVld = (lOp != OP_IDLE); lWr = (lOp == OP_REQ) || (lOp == OP_REL);
    lDin = (lOp == OP_REL);  lAddr = li;
    rVld = (rOp != OP_IDLE); rWr = (rOp == OP_REQ) || (rOp == OP_REL);
    rDin = (rOp == OP_REL);  rAddr = ri;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 left after reset", lRdata, '1);
    check("R1 right after reset", rRdata, '1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      drive(v[15:14], v[13:11], v[10:9], v[8:6]);
      @(negedge clk);
      if (v[15:14] == OP_RD)
        check($sformatf("R%0d left step %0d", v[3:0], i), lRdata, {DW{v[5]}});
      if (v[10:9] == OP_RD)
        check($sformatf("R%0d right step %0d", v[3:0], i), rRdata, {DW{v[4]}});
      if (v[15:14] == OP_RD && v[10:9] == OP_RD && v[13:11] == v[8:6])
        check($sformatf("R9 not both zero step %0d", i), {15'd0, lRdata[0] | rRdata[0]}, 16'd1);
    end

    // R10: read words hold across cycles without a read
    drive(OP_IDLE, 3'd0, OP_REQ, 3'd0);
    @(negedge clk);
    check("R10 left holds", lRdata, '0);
    check("R10 right holds", rRdata, '1);
    drive(OP_REL, 3'd0, OP_IDLE, 3'd0);
    @(negedge clk);
    check("R10 left holds after release", lRdata, '0);
    drive(OP_IDLE, 3'd0, OP_RD, 3'd0);
    @(negedge clk);
    check("R10 right sees handover next cycle", rRdata, '0);

    // R1: reset while right holds token 0
    drive(OP_IDLE, 3'd0, OP_IDLE, 3'd0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 left word on reset", lRdata, '1);
    check("R1 right word on reset", rRdata, '1);
    rst = 1'b0;
    for (int f = 0; f < 8; f++) begin
      drive(OP_RD, 3'(f), OP_RD, 3'(f));
      @(negedge clk);
      check($sformatf("R1 left token %0d free", f), lRdata, '1);
      check($sformatf("R1 right token %0d free", f), rRdata, '1);
    end
    drive(OP_IDLE, 3'd0, OP_IDLE, 3'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule